// File: doc/BRIEF.md
# Biphase-Mark Event Encoder

This block drives one serial timing line that carries a bit clock and event codes together. It runs on a clock at twice the bit rate, so every bit cell lasts two clock cycles. The line level inverts at the start of every cell. A one bit adds a second inversion halfway through its cell. When nothing is queued, the line sends zero bits without a break. The result is a regular square wave with one edge per cell, which receivers use to recover the clock.

Eight trigger inputs can ask for an event. Each input has its own 8-bit code in a flat table input. A rising edge on a trigger input marks that source pending. When the current frame has ended, the pending source with the lowest index is sent as one frame: three one bits, then the code with its most significant bit first, then a parity bit. A second request from a source that is still pending is merged into the one frame already waiting, and a sticky overflow flag is set. Code zero is reserved, and a source whose code is zero never sends a frame.

Top module: `bmce_encoder`

## Requirements
- R1: With nothing pending, every cell carries a zero: the line toggles once per cell, at the cell start, and never mid-cell.
- R2: Each cell lasts two clock cycles. After reset is released, the line toggles at the second rising edge and at every second edge after that. In a cell that carries a one, the line also toggles at the edge between these.
- R3: A frame is 12 cells long: three ones, then the 8-bit code with its most significant bit first, then a parity bit equal to the XOR of the code bits. The code plus the parity bit therefore hold an even number of ones.
- R4: A request is the rising edge of `trig_i[i]`. A level held high for many cycles makes exactly one frame. The code sent is `code_tbl_i[8*i +: 8]`, read when the frame is launched.
- R5: A frame is launched only at a cell boundary when no frame is in progress, so frames for sources already pending follow each other with no idle cell between them. Among the pending sources, the lowest index is served first. This applies to requests that were latched while another frame was being sent.
- R6: A rising edge on a source that is already pending and is not being launched in that cycle is merged, so that source sends only one frame. It also sets `ovf_o`, which stays high until reset.
- R7: Code 0x00 is never transmitted. A request from a source whose table entry is zero is discarded and does not set `ovf_o`.
- R8: While `rst` is high, `line_o` is low, `ovf_o` is low, and all pending requests are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (twice the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NUM_SRC | Trigger request inputs, one per source, acting on rising edges |
| code_tbl_i | input | NUM_SRC*8 | Event code per source, where source i occupies bits 8*i+7 down to 8*i |
| line_o | output | 1 | Biphase-mark serial timing line |
| ovf_o | output | 1 | Sticky flag set when a request is merged |

## Verification
The assertions assume that `trig_i` and `code_tbl_i` are synchronous to `clk`. They also assume that a table entry does not change between the request and the launch of its frame. The bench changes every input half a cycle away from the rising edge, and it rewrites the table only while no frame or request is outstanding. The bench decodes the line itself from samples taken on the falling edge, one pair per cell. For the decoder to line up its cells, reset must be released just after a falling edge, and the bench always releases it there.

// File: rtl/bmce_pkg.sv
package bmce_pkg;

    localparam int CODE_W    = 8;
    localparam int START_LEN = 3;
    localparam int FRAME_LEN = START_LEN + CODE_W + 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef logic [CODE_W-1:0] code_t;

    // Frame fields in transmit order, most significant first.
    typedef struct packed {
        logic [START_LEN-1:0] sync;
        code_t                code;
        logic                 par;
    } frame_t;

    typedef enum logic {
        HALF_LEAD  = 1'b0,
        HALF_TRAIL = 1'b1
    } half_e;

    function automatic logic even_par(code_t c);
        return ^c;
    endfunction

    function automatic frame_t build_frame(code_t c);
        frame_t f;
        f.sync = '1;
        f.code = c;
        f.par  = even_par(c);
        return f;
    endfunction

endpackage

// File: rtl/bmce_req_pick.sv
module bmce_req_pick
    import bmce_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        trig,
    input  logic [NUM_SRC*CODE_W-1:0] code_tbl,
    input  logic                      take,
    output logic                      have_req,
    output code_t                     sel_code,
    output logic                      ovf
);

    logic [NUM_SRC-1:0] trig_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] usable;
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] used;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_usable
        assign usable[g] = (code_tbl[g*CODE_W +: CODE_W] != '0);
    end

    assign rise     = trig & ~trig_q;
    assign cand     = pend_q & usable;
    assign have_req = |cand;
    assign used     = take ? grant : '0;

    // Lowest index wins: scan downward so the last hit is the lowest.
    always_comb begin
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    always_comb begin
        sel_code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (grant[i]) begin
                sel_code = sel_code | code_tbl[i*CODE_W +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            pend_q <= '0;
            ovf    <= 1'b0;
        end else begin
            trig_q <= trig;
            pend_q <= (cand & ~used) | (rise & usable);
            if (|(rise & usable & cand & ~used)) begin
                ovf <= 1'b1;
            end
        end
    end

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
        (take && have_req) |-> ((cand & (used - NUM_SRC'(1))) == '0)); // R5

    AST_NO_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
        (take && have_req) |-> (sel_code != '0)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf); // R6

    AST_MERGE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (|(rise & cand & ~used)) |=> ovf); // R6

endmodule

// File: rtl/bmce_framer.sv
module bmce_framer
    import bmce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cell_end,
    input  logic  have_req,
    input  code_t code_in,
    output logic  take,
    output logic  bit_o
);

    logic [FRAME_LEN-1:0] sr_q;
    logic [CNT_W-1:0]     left_q;
    logic [FRAME_LEN-1:0] fr_bits;

    assign take    = cell_end && (left_q == '0);
    assign fr_bits = build_frame(code_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            left_q <= '0;
            bit_o  <= 1'b0;
        end else if (cell_end) begin
            if (left_q != '0) begin
                bit_o  <= sr_q[FRAME_LEN-1];
                sr_q   <= sr_q << 1;
                left_q <= left_q - CNT_W'(1);
            end else if (have_req) begin
                bit_o  <= fr_bits[FRAME_LEN-1];
                sr_q   <= fr_bits << 1;
                left_q <= CNT_W'(FRAME_LEN - 1);
            end else begin
                bit_o  <= 1'b0;
            end
        end
    end

    AST_FRAME_OPENS_ONE: assert property (@(posedge clk) disable iff (rst)
        (take && have_req) |=> bit_o); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (take && !have_req) |=> !bit_o); // R1

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        left_q <= CNT_W'(FRAME_LEN - 1)); // R3

endmodule

// File: rtl/bmce_line.sv
module bmce_line
    import bmce_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    output logic cell_end,
    output logic line_o
);

    half_e half_q;
    logic  line_q;

    assign cell_end = (half_q == HALF_TRAIL);
    assign line_o   = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= HALF_LEAD;
            line_q <= 1'b0;
        end else if (half_q == HALF_TRAIL) begin
            half_q <= HALF_LEAD;
            line_q <= ~line_q;
        end else begin
            half_q <= HALF_TRAIL;
            if (bit_i) begin
                line_q <= ~line_q;
            end
        end
    end

    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (rst)
        cell_end |=> (line_q != $past(line_q))); // R2

    AST_MID_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!cell_end && !bit_i) |=> $stable(line_q)); // R1

    AST_MID_ONE: assert property (@(posedge clk) disable iff (rst)
        (!cell_end && bit_i) |=> !$stable(line_q)); // R2

endmodule

// File: rtl/bmce_encoder.sv
module bmce_encoder
    import bmce_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        trig_i,
    input  logic [NUM_SRC*CODE_W-1:0] code_tbl_i,
    output logic                      line_o,
    output logic                      ovf_o
);

    logic  take;
    logic  have_req;
    code_t sel_code;
    logic  cell_end;
    logic  cell_bit;

    bmce_req_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig_i),
        .code_tbl (code_tbl_i),
        .take     (take),
        .have_req (have_req),
        .sel_code (sel_code),
        .ovf      (ovf_o)
    );

    bmce_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .cell_end (cell_end),
        .have_req (have_req),
        .code_in  (sel_code),
        .take     (take),
        .bit_o    (cell_bit)
    );

    bmce_line u_line (
        .clk      (clk),
        .rst      (rst),
        .bit_i    (cell_bit),
        .cell_end (cell_end),
        .line_o   (line_o)
    );

endmodule

// File: tb/test_bmce_encoder.sv
module test_bmce_encoder;
    import bmce_pkg::*;

    localparam int NSRC = 8;
    localparam int NVEC = 6;
    localparam logic [NSRC-1:0] VEC_MASK [NVEC] =
        '{8'h01, 8'h80, 8'h05, 8'hFF, 8'hA0, 8'h42};

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NSRC-1:0]        trig = '0;
    logic [NSRC*CODE_W-1:0] tbl = '0;
    logic                   line;
    logic                   ovf;

    always #2 clk = ~clk;

    bmce_encoder #(.NUM_SRC(NSRC)) i_bmce_encoder (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (trig),
        .code_tbl_i (tbl),
        .line_o     (line),
        .ovf_o      (ovf)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // Line decoder: two samples per cell, taken on falling edges.
    int         half = 1;
    logic       fh = 1'b0;
    logic       psh = 1'b0;
    logic       rxb;
    int         run = 0;
    bit         collecting = 0;
    int         nbits = 0;
    logic [8:0] acc = '0;
    logic [7:0] ev_log [256];
    int         ev_cnt = 0;
    int         tog_err = 0;
    int         par_err = 0;
    int         one_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            half = 1; fh = 1'b0; psh = 1'b0;
            run = 0; collecting = 0; nbits = 0;
        end else if (half == 1) begin
            rxb = (line != fh);
            psh = line;
            half = 0;
            if (rxb) one_cnt++;
            if (collecting) begin
                acc = {acc[7:0], rxb};
                nbits++;
                if (nbits == 9) begin
                    if (ev_cnt < 256) ev_log[ev_cnt] = acc[8:1];
                    ev_cnt++;
                    if (acc[0] != ^acc[8:1]) par_err++;
                    collecting = 0;
                    run = 0;
                end
            end else if (rxb) begin
                run++;
                if (run == 3) begin
                    collecting = 1;
                    nbits = 0;
                end
            end else begin
                run = 0;
            end
        end else begin
            if (line == psh) tog_err++;
            fh = line;
            half = 1;
        end
    end

    function automatic logic [7:0] code_of(int i);
        return 8'((i + 1) * 16 + i + 2);
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse(logic [NSRC-1:0] m);
        trig = m;
        step(1);
        trig = '0;
        step(1);
    endtask

    task automatic load_tbl();
        for (int i = 0; i < NSRC; i++) tbl[i*8 +: 8] = code_of(i);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        int ones0;
        int expn;
        load_tbl();
        step(4);
        // R8: reset state
        chk(line == 1'b0, "R8", "line in reset", int'(line), 0);
        chk(ovf == 1'b0, "R8", "ovf in reset", int'(ovf), 0);
        rst = 1'b0;

        // R2: second edge after release toggles the line, first does not
        @(posedge clk); #1;
        chk(line == 1'b0, "R2", "line after first edge", int'(line), 0);
        @(posedge clk); #1;
        chk(line == 1'b1, "R2", "line after second edge", int'(line), 1);
        step(1);

        // R1: idle line carries only zeros
        base = ev_cnt; ones0 = one_cnt;
        step(40);
        chk(one_cnt == ones0, "R1", "ones while idle", one_cnt - ones0, 0);
        chk(ev_cnt == base, "R1", "events while idle", ev_cnt - base, 0);

        // Vector table: simultaneous requests, R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            base = ev_cnt;
            pulse(VEC_MASK[v]);
            step(260);
            expn = 0;
            for (int i = 0; i < NSRC; i++) begin
                if (VEC_MASK[v][i]) begin
                    chk(ev_cnt > base + expn && ev_log[base + expn] == code_of(i),
                        "R5", "code in priority order",
                        int'(ev_log[base + expn]), int'(code_of(i)));
                    expn++;
                end
            end
            chk(ev_cnt - base == expn, "R4", "frame count", ev_cnt - base, expn);
        end
        chk(par_err == 0, "R3", "parity errors", par_err, 0);
        chk(ovf == 1'b0, "R6", "ovf after clean requests", int'(ovf), 0);

        // R5: requests latched during a frame follow index order
        base = ev_cnt;
        pulse(8'h10);
        step(6);
        pulse(8'h40);
        step(2);
        pulse(8'h02);
        step(120);
        chk(ev_cnt - base == 3, "R5", "late request count", ev_cnt - base, 3);
        chk(ev_log[base] == code_of(4), "R5", "first late", int'(ev_log[base]), int'(code_of(4)));
        chk(ev_log[base + 1] == code_of(1), "R5", "second late", int'(ev_log[base + 1]), int'(code_of(1)));
        chk(ev_log[base + 2] == code_of(6), "R5", "third late", int'(ev_log[base + 2]), int'(code_of(6)));

        // R4: held level gives one frame
        base = ev_cnt;
        trig = 8'h08;
        step(150);
        trig = '0;
        step(40);
        chk(ev_cnt - base == 1, "R4", "held level frames", ev_cnt - base, 1);
        chk(ev_log[base] == code_of(3), "R4", "held level code", int'(ev_log[base]), int'(code_of(3)));
        chk(ovf == 1'b0, "R4", "held level ovf", int'(ovf), 0);

        // R7: zero code never sent
        tbl[5*8 +: 8] = 8'h00;
        base = ev_cnt;
        pulse(8'h20);
        step(60);
        chk(ev_cnt == base, "R7", "zero code frames", ev_cnt - base, 0);
        pulse(8'h21);
        step(60);
        chk(ev_cnt - base == 1 && ev_log[base] == code_of(0), "R7", "only nonzero sent",
            ev_cnt - base, 1);
        pulse(8'h20);
        pulse(8'h20);
        step(10);
        chk(ovf == 1'b0, "R7", "zero code ovf", int'(ovf), 0);
        load_tbl();
        step(4);

        // R6: merge while pending
        base = ev_cnt;
        pulse(8'h02);
        step(6);
        pulse(8'h04);
        pulse(8'h04);
        step(3);
        chk(ovf == 1'b1, "R6", "ovf after merge", int'(ovf), 1);
        step(100);
        chk(ev_cnt - base == 2, "R6", "merged frame count", ev_cnt - base, 2);
        chk(ev_log[base + 1] == code_of(2), "R6", "merged code", int'(ev_log[base + 1]), int'(code_of(2)));
        chk(ovf == 1'b1, "R6", "ovf sticky", int'(ovf), 1);

        // R8: reset clears the flag and the line
        rst = 1'b1;
        step(3);
        chk(ovf == 1'b0, "R8", "ovf cleared", int'(ovf), 0);
        chk(line == 1'b0, "R8", "line cleared", int'(line), 0);
        rst = 1'b0;
        step(40);
        chk(tog_err == 0, "R2", "missing cell-start toggles", tog_err, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule